// File: doc/BRIEF.md
# Infrared Carrier Envelope Demodulator

This block turns a carrier-modulated infrared signal into a baseband mark/space envelope for a downstream pulse-width receiver. A programmable divider derives a tick from the system clock, one tick every `div_val + 1` cycles. The block measures the spacing between successive rising edges of the synchronized input in ticks. A nominal carrier period is 16 ticks. A spacing that falls inside a tolerance window around 16 ticks counts as a valid carrier cycle. Two such cycles in a row declare mark. Space returns when the carrier stops.

The tolerance on each side of the nominal period is 3 ticks by default. Each side can be widened to 4 ticks on its own through `win_sel`. An edge that comes too early is treated as noise: it discards the run of valid cycles and restarts the measurement. With demodulation turned off, the block passes the synchronized raw input straight to its output and holds the measuring logic cleared.

Top module: `irdm_carrier_demod`

## Requirements
- R1: After reset, and while reset is held, `env_out` is 0 when `ir_in` is low.
- R2: With `demod_en` = 0, `env_out` equals `ir_in` delayed by exactly two clock cycles.
- R3: Periods are counted in divided ticks, one tick every `div_val + 1` clock cycles. The same tick counts are accepted for any divider value, and a clock-cycle spacing that gives the wrong tick count is rejected.
- R4: A spacing between rising edges is in-window when it lies between the low and high limits, both included. Mark (`env_out` = 1) is declared on the second consecutive in-window spacing, and not on the first. With `div_val` = 0, `env_out` rises three clock cycles after the input edge that completes the run.
- R5: `win_sel[0]` sets the low limit: 13 ticks when it is 0, 12 ticks when it is 1.
- R6: `win_sel[1]` sets the high limit: 19 ticks when it is 0, 20 ticks when it is 1.
- R7: If no rising edge arrives within the high limit, `env_out` returns to 0 at high limit + 1 ticks after the last edge. With `div_val` = 0, it is still 1 at high limit + 3 cycles after the input rise and 0 one cycle later. The next edge then starts a new measurement.
- R8: An edge that arrives before the low limit clears the run of valid spacings and restarts measurement. It never raises mark. A mark already present is kept until the timeout.
- R9: Clearing `demod_en` clears the envelope, the run and the period count. After it is set again, a fresh run of three rising edges is needed for mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ir_in | input | 1 | Raw infrared input, asynchronous to clk |
| div_val | input | 16 | Tick divider; one tick every div_val+1 cycles |
| demod_en | input | 1 | 1 selects the demodulated envelope, 0 the raw input |
| win_sel | input | 2 | Bit 0 widens the early tolerance, bit 1 the late tolerance |
| env_out | output | 1 | Envelope: 1 for mark, 0 for space |

## Verification
The assertions check several rules on every cycle:
- The divider never issues two ticks back to back unless the divider value is zero.
- An edge pulse lasts one cycle.
- Mark rises only on a cycle that follows a detected edge.
- An early edge never raises mark.
- Mark falls from an enabled state only when the period count has reached the high limit.

The bench's scenarios show which spacings are accepted, as exact boundary values for all four window settings and several divider values. They also show the cycle-exact timeout, the restart after a noise edge, the bypass latency and the clearing of state when demodulation is turned off.

// File: rtl/irdm_pkg.sv
package irdm_pkg;

  // Classification of one synchronized rising edge against the window
  typedef enum logic [1:0] {
    PC_NONE  = 2'd0,
    PC_EARLY = 2'd1,
    PC_HIT   = 2'd2,
    PC_LATE  = 2'd3
  } pclass_t;

endpackage

// File: rtl/irdm_tick_div.sv
module irdm_tick_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  always_comb begin
    tick_o = (cnt_q >= div_val);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_val != '0) |=> (!tick_o || div_val == '0));

endmodule

// File: rtl/irdm_sync_edge.sv
module irdm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic raw_o,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign raw_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R4
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/irdm_period_chk.sv
module irdm_period_chk
  import irdm_pkg::*;
#(
  parameter int PER_TICKS = 16,
  parameter int TOL_BASE  = 3,
  parameter int MARK_RUN  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       edge_in,
  input  logic [1:0] win_sel,
  output logic       env_o
);

  localparam int CNT_MAX = 2 * PER_TICKS - 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int MEAS_W  = CNT_W + 1;
  localparam int RUN_W   = $clog2(MARK_RUN + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [RUN_W-1:0]  run_q, run_d;
  logic              env_q, env_d;
  logic [MEAS_W-1:0] meas, lo_lim, hi_lim;
  pclass_t           pcls;

  // Window limits and classification of the current edge
  always_comb begin
    lo_lim = MEAS_W'(PER_TICKS - TOL_BASE) - MEAS_W'(win_sel[0]);
    hi_lim = MEAS_W'(PER_TICKS + TOL_BASE) + MEAS_W'(win_sel[1]);
    meas   = {1'b0, cnt_q} + MEAS_W'(tick);
    if (!edge_in)          pcls = PC_NONE;
    else if (meas < lo_lim) pcls = PC_EARLY;
    else if (meas > hi_lim) pcls = PC_LATE;
    else                    pcls = PC_HIT;
  end

  // Next state
  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    env_d = env_q;
    if (!en) begin
      cnt_d = '0;
      run_d = '0;
      env_d = 1'b0;
    end else begin
      unique case (pcls)
        PC_NONE: begin
          if (tick) begin
            if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
            if ({1'b0, cnt_q} == hi_lim) begin
              env_d = 1'b0;
              run_d = '0;
            end
          end
        end
        PC_EARLY, PC_LATE: begin
          cnt_d = '0;
          run_d = '0;
        end
        PC_HIT: begin
          cnt_d = '0;
          if (run_q >= RUN_W'(MARK_RUN - 1)) begin
            env_d = 1'b1;
            run_d = RUN_W'(MARK_RUN);
          end else begin
            run_d = run_q + 1'b1;
          end
        end
        default: begin
          cnt_d = '0;
          run_d = '0;
        end
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= '0;
      env_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      env_q <= env_d;
    end
  end

  assign env_o = env_q;

  // R4
  mark_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(env_q) |-> $past(edge_in));

  // R8
  early_no_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pcls == PC_EARLY) |=> !$rose(env_q));

  // R7
  space_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(env_q) && $past(en)) |-> ({1'b0, $past(cnt_q)} == $past(hi_lim)));

  // R9
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !env_q);

endmodule

// File: rtl/irdm_carrier_demod.sv
module irdm_carrier_demod #(
  parameter int DIV_W       = 16,
  parameter int PER_TICKS   = 16,
  parameter int TOL_BASE    = 3,
  parameter int MARK_RUN    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_in,
  input  logic [DIV_W-1:0] div_val,
  input  logic             demod_en,
  input  logic [1:0]       win_sel,
  output logic             env_out
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       tick;
  logic       raw_sync;
  logic       rise;
  logic       env_dm;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irdm_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .div_val (div_val),
    .tick_o  (tick)
  );

  irdm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .din    (ir_in),
    .raw_o  (raw_sync),
    .rise_o (rise)
  );

  irdm_period_chk #(
    .PER_TICKS (PER_TICKS),
    .TOL_BASE  (TOL_BASE),
    .MARK_RUN  (MARK_RUN)
  ) u_per (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (demod_en),
    .tick    (tick),
    .edge_in (rise),
    .win_sel (win_sel),
    .env_o   (env_dm)
  );

  assign env_out = demod_en ? env_dm : raw_sync;

  // R1
  reset_space_chk: assert property (@(posedge clk)
    (!rst_int_n && demod_en) |-> !env_out);

endmodule

// File: tb/tb_irdm_carrier_demod.sv
`timescale 1ns/1ps
module tb_irdm_carrier_demod;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ir_in;
  logic [15:0] div_val;
  logic        demod_en;
  logic [1:0]  win_sel;
  logic        env_out;

  int n_chk  = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  irdm_carrier_demod dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ir_in    (ir_in),
    .div_val  (div_val),
    .demod_en (demod_en),
    .win_sel  (win_sel),
    .env_out  (env_out)
  );

  task automatic chk(input logic exp, input string tag);
    n_chk++;
    if (env_out !== exp) begin
      n_fail++;
      $display("FAIL %s: env_out=%0b expected=%0b at %0t", tag, env_out, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Rising edge now; the next rising edge follows len cycles later.
  // Optional check four cycles after the rise.
  task automatic pulse(input int len, input bit do_chk, input logic exp, input string tag);
    ir_in = 1'b1;
    wait_n(3);
    ir_in = 1'b0;
    wait_n(1);
    if (do_chk) chk(exp, tag);
    wait_n(len - 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    logic d1, d2;
    int lo, hi;
    logic exp;
    string tag;

    rst_n = 1'b0; ir_in = 1'b0; div_val = 16'd0; demod_en = 1'b1; win_sel = 2'b00;
    wait_n(4);
    chk(1'b0, "R1 in reset");
    rst_n = 1'b1;
    wait_n(6);
    chk(1'b0, "R1 after reset");

    // R2: bypass with a pseudo-random input pattern
    demod_en = 1'b0;
    lf = 8'hA5; d1 = 1'b0; d2 = 1'b0;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (i >= 2) chk(d2, "R2 bypass");
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      d2 = d1; d1 = lf[0];
      ir_in = lf[0];
    end
    ir_in = 1'b0;
    wait_n(4);
    demod_en = 1'b1;
    wait_n(2);

    // Sweep: divider, window setting, spacing in ticks (R3..R7)
    for (int d = 0; d < 3; d++) begin
      for (int w = 0; w < 4; w++) begin
        for (int p = 10; p <= 22; p++) begin
          lo  = 13 - (w & 1);
          hi  = 19 + (w >> 1);
          exp = (p >= lo && p <= hi);
          if (p == lo || p == lo - 1)      tag = "R5 low limit";
          else if (p == hi || p == hi + 1) tag = "R6 high limit";
          else if (d > 0)                  tag = "R3 divided ticks";
          else                             tag = "R4 window";
          div_val = 16'(d);
          win_sel = 2'(w);
          wait_n(40 * (d + 1) + 8);
          chk(1'b0, "R7 idle space");
          pulse(p * (d + 1), 1'b0, 1'b0, "");
          pulse(p * (d + 1), 1'b1, 1'b0, "R4 one spacing only");
          pulse(p * (d + 1), 1'b1, exp, tag);
        end
      end
    end

    // R3: clock-cycle spacing that is wrong in ticks
    div_val = 16'd2; win_sel = 2'b00;
    wait_n(140);
    pulse(16, 1'b0, 1'b0, "");
    pulse(16, 1'b0, 1'b0, "");
    pulse(16, 1'b1, 1'b0, "R3 16 cycles at div 2");
    wait_n(140);
    pulse(48, 1'b0, 1'b0, "");
    pulse(48, 1'b0, 1'b0, "");
    pulse(48, 1'b1, 1'b1, "R3 48 cycles at div 2");

    // R7: exact timeout, both high-limit settings, div 0
    div_val = 16'd0;
    for (int w = 0; w < 2; w++) begin
      win_sel = (w == 0) ? 2'b00 : 2'b10;
      hi = (w == 0) ? 19 : 20;
      wait_n(150);
      pulse(16, 1'b0, 1'b0, "");
      pulse(16, 1'b0, 1'b0, "");
      ir_in = 1'b1;
      wait_n(3);
      chk(1'b1, "R4 mark three cycles after edge");
      ir_in = 1'b0;
      wait_n(hi);
      chk(1'b1, "R7 still mark at limit");
      wait_n(1);
      chk(1'b0, "R7 space after limit");
      pulse(16, 1'b0, 1'b0, "");
      pulse(16, 1'b1, 1'b0, "R7 restart after timeout");
      pulse(16, 1'b1, 1'b1, "R7 new run after timeout");
    end

    // R8: early edge clears the run, keeps an existing mark
    win_sel = 2'b00;
    wait_n(60);
    pulse(16, 1'b0, 1'b0, "");
    pulse(8,  1'b0, 1'b0, "");
    pulse(16, 1'b1, 1'b0, "R8 early edge");
    pulse(16, 1'b1, 1'b0, "R8 run restarted");
    pulse(6,  1'b1, 1'b1, "R8 mark after fresh run");
    pulse(16, 1'b1, 1'b1, "R8 mark held over early edge");
    wait_n(60);

    // R9: disable clears state
    pulse(16, 1'b0, 1'b0, "");
    pulse(16, 1'b0, 1'b0, "");
    ir_in = 1'b1;
    wait_n(3);
    ir_in = 1'b0;
    wait_n(2);
    chk(1'b1, "R9 mark before disable");
    demod_en = 1'b0;
    wait_n(2);
    chk(1'b0, "R2 raw low while off");
    ir_in = 1'b1;
    wait_n(2);
    chk(1'b1, "R2 raw high while off");
    ir_in = 1'b0;
    wait_n(3);
    demod_en = 1'b1;
    wait_n(2);
    chk(1'b0, "R9 cleared on re-enable");
    pulse(16, 1'b0, 1'b0, "");
    pulse(16, 1'b1, 1'b0, "R9 fresh run needed");
    pulse(16, 1'b1, 1'b1, "R9 mark after fresh run");
    wait_n(40);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule